// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds the fetch state of every hardware thread in a multithreaded front end. Each cycle it updates that state from the feedback that later pipeline stages send back. Four downstream stages raise block and unblock pulses, and a global context-switch flag stalls every thread at once. Commit and decode can request a squash with a new fetch address, and commit can report that its reorder buffer is still draining a squash. The instruction cache reports when a line request of a thread has missed and when that miss is filled.

The controller settles all of these inputs per thread with a fixed priority: commit squash first, then reorder-buffer squashing, then decode squash, then stall, then recovery to Running. For every thread it drives the current state, the redirected fetch address and the address that follows it, and the tag of its outstanding line request. It also drives one stage-active flag, which is high whenever some enabled thread can make progress.

Miss completions carry the tag of the request they answer. A thread takes a completion only if it is still waiting on a miss and the tag matches its most recent request. A squash therefore makes any fill that is still in flight stale.

Top module: `fsc_top`

## Requirements
- R1: After reset, every thread is in Running (code 0), with fetch address RESET_PC, next address RESET_PC+INST_BYTES and request tag 0. No stage stall bit is set. State codes are: Running 0, Idle 1, Squashing 2, Blocked 3, IcacheMissStall 4, IcacheMissComplete 5, TrapPending 6, QuiescePending 7.
- R2: Each of a thread's four stage stall bits is set by its block pulse and cleared by its unblock pulse, and keeps its value in between. Stage s of thread t is bit t*4+s of the block and unblock vectors. A thread with a set bit that is not in IcacheMissStall enters Blocked at the next edge and stays there. The cycle that clears its last bit returns it to Running.
- R3: When the context-switch flag is high, every enabled thread that is not in IcacheMissStall enters Blocked at the next edge.
- R4: A commit squash has the highest priority. The thread enters Squashing, its fetch address becomes the commit target and its next address becomes the target plus INST_BYTES, whatever else arrives in the same cycle.
- R5: Without a commit squash, reorder-buffer squashing puts the thread in Squashing and leaves its addresses unchanged, even when a decode squash arrives in the same cycle.
- R6: Without either of those, a decode squash redirects the thread to the decode target and enters Squashing. A decode squash that arrives while the thread is already in Squashing changes no address.
- R7: When no squash and no stall is present, a thread in Blocked or Squashing returns to Running at the next edge.
- R8: A miss start in Running moves the thread to IcacheMissStall and increments its request tag by one, modulo 2^TAG_W. Stalls do not move a thread out of IcacheMissStall.
- R9: A completion is accepted only in IcacheMissStall and only with a tag equal to the thread's current tag. An accepted completion leads to IcacheMissComplete if the thread is unstalled and to Blocked if it is stalled. A completion with a different tag leaves the thread in IcacheMissStall.
- R10: After a squash, the completion for the request that was outstanding at the squash is ignored, even once the thread waits on a newer miss.
- R11: A thread in IcacheMissComplete moves to Running in a cycle where it is selected, and stays in IcacheMissComplete otherwise. No new request is made, so its tag does not change.
- R12: The stage-active output is high exactly when at least one enabled thread is in Running, Squashing or IcacheMissComplete.
- R13: A thread whose enable is low keeps its state and addresses whatever squash or stall input arrives. Its stall bits still follow block and unblock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thread_en_i | input | NT | Thread enable (thread takes part in updates) |
| ctx_switch_i | input | 1 | Global context-switch stall |
| stage_block_i | input | NT*NS | Block pulse, bit t*NS+s for stage s of thread t |
| stage_unblock_i | input | NT*NS | Unblock pulse, same layout |
| cmt_squash_i | input | NT | Commit squash request |
| cmt_target_i | input | NT*PC_W | Commit redirect address per thread |
| rob_squashing_i | input | NT | Reorder buffer still squashing |
| dec_squash_i | input | NT | Decode squash request |
| dec_target_i | input | NT*PC_W | Decode redirect address per thread |
| miss_start_i | input | NT | Line request of the thread missed |
| fill_valid_i | input | NT | Miss completion event |
| fill_tag_i | input | NT*TAG_W | Tag carried by the completion |
| sel_i | input | NT | Thread selected for fetch this cycle |
| state_o | output | NT*3 | Per-thread state code |
| pc_o | output | NT*PC_W | Per-thread fetch address |
| npc_o | output | NT*PC_W | Per-thread next fetch address |
| req_tag_o | output | NT*TAG_W | Per-thread tag of the latest request |
| active_o | output | 1 | Stage-active flag |

## Verification
The functions most likely to meet in one cycle are squash resolution and stall tracking. The bench drives every combination of commit squash, reorder-buffer squashing, decode squash and a block pulse into one thread at once. It judges the resulting state and addresses against the priority order, and then checks that the sticky stall bit left by the block still holds the thread afterwards. A miss completion is also made to arrive together with a block pulse, which must give Blocked rather than IcacheMissComplete. A stale-tag fill is sent after a squash to confirm that it cannot wake the newer miss.

// File: rtl/fsc_pkg.sv
// Package: shared state encoding for the fetch status controller.
// Assumes a 3-bit code; the ordering is visible at the state_o port.
package fsc_pkg;
    typedef enum logic [2:0] {
        ST_RUN        = 3'd0,
        ST_IDLE       = 3'd1,
        ST_SQUASH     = 3'd2,
        ST_BLOCKED    = 3'd3,
        ST_MISS_WAIT  = 3'd4,
        ST_MISS_DONE  = 3'd5,
        ST_TRAP_WAIT  = 3'd6,
        ST_QUIET_WAIT = 3'd7
    } fsc_state_t;
endpackage

// File: rtl/fsc_stall_track.sv
// Module: sticky per-stage stall bits of one thread.
// Each stage bit is set by its block pulse and cleared by its unblock pulse.
// Assumes a block and an unblock never arrive together for one stage.
// Drives the updated bit vector so the same-cycle decision sees it.
module fsc_stall_track #(
    parameter int NS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] block_i,
    input  logic [NS-1:0] unblock_i,
    input  logic          ctx_switch_i,
    output logic [NS-1:0] bits_q,
    output logic          stalled_o
);
    logic [NS-1:0] bits_d;

    // Next value of every stage bit: block wins, then unblock, else hold.
    always_comb begin
        for (int s = 0; s < NS; s++) begin
            bits_d[s] = block_i[s] ? 1'b1 : (unblock_i[s] ? 1'b0 : bits_q[s]);
        end
    end

    // Register the stage bits.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    // The thread is stalled by the global flag or by any updated stage bit.
    assign stalled_o = ctx_switch_i | (|bits_d);
endmodule

// File: rtl/fsc_thread_fsm.sv
// Module: fetch state, redirect addresses and request tag of one thread.
// Resolves commit squash, then reorder-buffer squashing, then decode squash,
// then stall, then recovery, then the miss and select events.
// Assumes 'stalled_i' already reflects this cycle's stall pulses.
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int          PC_W       = 32,
    parameter int          TAG_W      = 3,
    parameter int          INST_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             stalled_i,
    input  logic             cmt_sq_i,
    input  logic [PC_W-1:0]  cmt_tgt_i,
    input  logic             rob_sq_i,
    input  logic             dec_sq_i,
    input  logic [PC_W-1:0]  dec_tgt_i,
    input  logic             miss_start_i,
    input  logic             fill_v_i,
    input  logic [TAG_W-1:0] fill_tag_i,
    input  logic             sel_i,
    output fsc_state_t       st_q,
    output logic [PC_W-1:0]  pc_q,
    output logic [PC_W-1:0]  npc_q,
    output logic [TAG_W-1:0] tag_q
);
    localparam logic [PC_W-1:0] STEP  = PC_W'(INST_BYTES);
    localparam logic [PC_W-1:0] PC0   = RESET_PC[PC_W-1:0];

    fsc_state_t       st_d;
    logic [PC_W-1:0]  pc_d, npc_d;
    logic [TAG_W-1:0] tag_d;

    // Priority resolution of the next state, addresses and tag.
    always_comb begin
        st_d  = st_q;
        pc_d  = pc_q;
        npc_d = npc_q;
        tag_d = tag_q;
        if (en_i) begin
            if (cmt_sq_i) begin
                st_d  = ST_SQUASH;
                pc_d  = cmt_tgt_i;
                npc_d = cmt_tgt_i + STEP;
            end else if (rob_sq_i) begin
                st_d = ST_SQUASH;
            end else if (dec_sq_i && st_q != ST_SQUASH) begin
                st_d  = ST_SQUASH;
                pc_d  = dec_tgt_i;
                npc_d = dec_tgt_i + STEP;
            end else if (stalled_i && st_q != ST_MISS_WAIT) begin
                st_d = ST_BLOCKED;
            end else if (st_q == ST_BLOCKED || st_q == ST_SQUASH) begin
                st_d = ST_RUN;
            end else begin
                case (st_q)
                    ST_MISS_WAIT: begin
                        if (fill_v_i && fill_tag_i == tag_q)
                            st_d = stalled_i ? ST_BLOCKED : ST_MISS_DONE;
                    end
                    ST_MISS_DONE: begin
                        if (sel_i) st_d = ST_RUN;
                    end
                    ST_RUN: begin
                        if (miss_start_i) begin
                            st_d  = ST_MISS_WAIT;
                            tag_d = tag_q + 1'b1;
                        end
                    end
                    default: st_d = st_q;
                endcase
            end
        end
    end

    // State registers with synchronous reset to Running at RESET_PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            pc_q  <= PC0;
            npc_q <= PC0 + STEP;
            tag_q <= '0;
        end else begin
            st_q  <= st_d;
            pc_q  <= pc_d;
            npc_q <= npc_d;
            tag_q <= tag_d;
        end
    end
endmodule

// File: rtl/fsc_top.sv
// Module: per-thread fetch status controller, top level.
// Instantiates a stall tracker and a state machine per thread and derives
// the stage-active flag. Per-thread vectors are packed thread-major.
module fsc_top
    import fsc_pkg::*;
#(
    parameter int          NT         = 2,
    parameter int          NS         = 4,
    parameter int          PC_W       = 32,
    parameter int          TAG_W      = 3,
    parameter int          INST_BYTES = 4,
    parameter logic [31:0] RESET_PC   = 32'h100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NT-1:0]       thread_en_i,
    input  logic                ctx_switch_i,
    input  logic [NT*NS-1:0]    stage_block_i,
    input  logic [NT*NS-1:0]    stage_unblock_i,
    input  logic [NT-1:0]       cmt_squash_i,
    input  logic [NT*PC_W-1:0]  cmt_target_i,
    input  logic [NT-1:0]       rob_squashing_i,
    input  logic [NT-1:0]       dec_squash_i,
    input  logic [NT*PC_W-1:0]  dec_target_i,
    input  logic [NT-1:0]       miss_start_i,
    input  logic [NT-1:0]       fill_valid_i,
    input  logic [NT*TAG_W-1:0] fill_tag_i,
    input  logic [NT-1:0]       sel_i,
    output logic [NT*3-1:0]     state_o,
    output logic [NT*PC_W-1:0]  pc_o,
    output logic [NT*PC_W-1:0]  npc_o,
    output logic [NT*TAG_W-1:0] req_tag_o,
    output logic                active_o
);
    logic [NT*NS-1:0] stall_bits;
    logic [NT-1:0]    stalled;
    logic [NT-1:0]    can_go;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        fsc_state_t st;

        fsc_stall_track #(.NS(NS)) u_stall (
            .clk          (clk),
            .rst_n        (rst_n),
            .block_i      (stage_block_i[t*NS +: NS]),
            .unblock_i    (stage_unblock_i[t*NS +: NS]),
            .ctx_switch_i (ctx_switch_i),
            .bits_q       (stall_bits[t*NS +: NS]),
            .stalled_o    (stalled[t])
        );

        fsc_thread_fsm #(
            .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)
        ) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (thread_en_i[t]),
            .stalled_i    (stalled[t]),
            .cmt_sq_i     (cmt_squash_i[t]),
            .cmt_tgt_i    (cmt_target_i[t*PC_W +: PC_W]),
            .rob_sq_i     (rob_squashing_i[t]),
            .dec_sq_i     (dec_squash_i[t]),
            .dec_tgt_i    (dec_target_i[t*PC_W +: PC_W]),
            .miss_start_i (miss_start_i[t]),
            .fill_v_i     (fill_valid_i[t]),
            .fill_tag_i   (fill_tag_i[t*TAG_W +: TAG_W]),
            .sel_i        (sel_i[t]),
            .st_q         (st),
            .pc_q         (pc_o[t*PC_W +: PC_W]),
            .npc_q        (npc_o[t*PC_W +: PC_W]),
            .tag_q        (req_tag_o[t*TAG_W +: TAG_W])
        );

        assign state_o[t*3 +: 3] = st;
        // A thread can make progress when enabled and in a live state.
        assign can_go[t] = thread_en_i[t] &&
                           (st == ST_RUN || st == ST_SQUASH || st == ST_MISS_DONE);
    end

    // Stage is active while any enabled thread can make progress.
    assign active_o = |can_go;
endmodule

// File: rtl/fsc_checker.sv
// Module: assertion checker for fsc_top, attached with bind below.
// Assumes the top's per-thread packing and its internal stall bit vector.
module fsc_checker
    import fsc_pkg::*;
#(
    parameter int NT    = 2,
    parameter int NS    = 4,
    parameter int PC_W  = 32,
    parameter int TAG_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NT-1:0]       thread_en_i,
    input logic                ctx_switch_i,
    input logic [NT*NS-1:0]    stage_block_i,
    input logic [NT*NS-1:0]    stage_unblock_i,
    input logic [NT-1:0]       cmt_squash_i,
    input logic [NT*PC_W-1:0]  cmt_target_i,
    input logic [NT-1:0]       rob_squashing_i,
    input logic [NT-1:0]       dec_squash_i,
    input logic [NT*3-1:0]     state_o,
    input logic [NT*PC_W-1:0]  pc_o,
    input logic [NT*TAG_W-1:0] req_tag_o,
    input logic [NT*NS-1:0]    stall_bits
);
    for (genvar i = 0; i < NT*NS; i++) begin : g_bit
        // R2: an unblock needs a set bit and no block in the same cycle.
        a_r2_unblock_legal: assert property (@(posedge clk) disable iff (!rst_n)
            stage_unblock_i[i] |-> (stall_bits[i] && !stage_block_i[i]));
    end

    for (genvar t = 0; t < NT; t++) begin : g_thr
        // R4: a commit squash on an enabled thread redirects to its target.
        a_r4_commit_redirect: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_en_i[t] && cmt_squash_i[t]) |=>
            (state_o[t*3 +: 3] == 3'(ST_SQUASH) &&
             pc_o[t*PC_W +: PC_W] == $past(cmt_target_i[t*PC_W +: PC_W])));

        // R3: a context switch blocks a thread outside miss wait when no squash.
        a_r3_ctx_blocks: assert property (@(posedge clk) disable iff (!rst_n)
            (thread_en_i[t] && ctx_switch_i && !cmt_squash_i[t] &&
             !rob_squashing_i[t] && !dec_squash_i[t] &&
             state_o[t*3 +: 3] != 3'(ST_MISS_WAIT)) |=>
            state_o[t*3 +: 3] == 3'(ST_BLOCKED));

        // R8: entering miss wait advances the request tag by exactly one.
        a_r8_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(state_o[t*3 +: 3]) != 3'(ST_MISS_WAIT) &&
             state_o[t*3 +: 3] == 3'(ST_MISS_WAIT)) |->
            req_tag_o[t*TAG_W +: TAG_W] == $past(req_tag_o[t*TAG_W +: TAG_W]) + 1'b1);

        // R9: miss complete can only be entered from miss wait.
        a_r9_done_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(state_o[t*3 +: 3]) != 3'(ST_MISS_DONE) &&
             state_o[t*3 +: 3] == 3'(ST_MISS_DONE)) |->
            $past(state_o[t*3 +: 3]) == 3'(ST_MISS_WAIT));

        // R13: a disabled thread keeps its state.
        a_r13_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !thread_en_i[t] |=> $stable(state_o[t*3 +: 3]));
    end
endmodule

bind fsc_top fsc_checker #(.NT(NT), .NS(NS), .PC_W(PC_W), .TAG_W(TAG_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .thread_en_i     (thread_en_i),
    .ctx_switch_i    (ctx_switch_i),
    .stage_block_i   (stage_block_i),
    .stage_unblock_i (stage_unblock_i),
    .cmt_squash_i    (cmt_squash_i),
    .cmt_target_i    (cmt_target_i),
    .rob_squashing_i (rob_squashing_i),
    .dec_squash_i    (dec_squash_i),
    .state_o         (state_o),
    .pc_o            (pc_o),
    .req_tag_o       (req_tag_o),
    .stall_bits      (stall_bits)
);

// File: tb/tb_fsc_top.sv
// Bench for fsc_top: directed sweeps with arithmetic expected values.
module tb_fsc_top;
    localparam int NT = 2, NS = 4, PC_W = 32, TAG_W = 3, IB = 4;
    localparam logic [31:0] RPC = 32'h100;
    localparam int RUN = 0, SQ = 2, BLK = 3, MW = 4, MD = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NT-1:0] en, cmt, rob, dec, mst, fv, sel;
    logic ctx;
    logic [NT*NS-1:0] blk, ublk;
    logic [NT*PC_W-1:0] ctgt, dtgt;
    logic [NT*TAG_W-1:0] ftag;
    logic [NT*3-1:0] st;
    logic [NT*PC_W-1:0] pc, npc;
    logic [NT*TAG_W-1:0] tag;
    logic act;
    int checks = 0, errors = 0;
    logic [31:0] pcm;

    always #5 clk = ~clk;

    fsc_top #(.NT(NT), .NS(NS), .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(IB), .RESET_PC(RPC)) dut (
        .clk(clk), .rst_n(rst_n), .thread_en_i(en), .ctx_switch_i(ctx),
        .stage_block_i(blk), .stage_unblock_i(ublk), .cmt_squash_i(cmt),
        .cmt_target_i(ctgt), .rob_squashing_i(rob), .dec_squash_i(dec),
        .dec_target_i(dtgt), .miss_start_i(mst), .fill_valid_i(fv),
        .fill_tag_i(ftag), .sel_i(sel), .state_o(st), .pc_o(pc), .npc_o(npc),
        .req_tag_o(tag), .active_o(act));

    task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, a, e);
        end
    endtask

    task automatic clr();
        cmt = '0; rob = '0; dec = '0; mst = '0; fv = '0; sel = '0; ctx = 1'b0;
        blk = '0; ublk = '0; ftag = '0;
    endtask

    // One clock edge, then sample and clear the pulses away from the edge.
    task automatic step();
        @(posedge clk); #2;
    endtask

    function automatic logic [31:0] sv(input int t);
        return 32'(st[t*3 +: 3]);
    endfunction
    function automatic logic [31:0] pv(input int t);
        return pc[t*PC_W +: PC_W];
    endfunction
    function automatic logic [31:0] nv(input int t);
        return npc[t*PC_W +: PC_W];
    endfunction
    function automatic logic [31:0] tv(input int t);
        return 32'(tag[t*TAG_W +: TAG_W]);
    endfunction

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        en = '1; ctgt = '0; dtgt = '0; clr();
        repeat (3) step();
        rst_n = 1'b1; step(); clr();
        for (int t = 0; t < NT; t++) begin
            chk("R1 state", sv(t), RUN);
            chk("R1 pc", pv(t), RPC);
            chk("R1 npc", nv(t), RPC + IB);
            chk("R1 tag", tv(t), 0);
        end
        chk("R12 active at reset", 32'(act), 1);

        // R2: sweep every thread and stage through block, hold, unblock.
        for (int t = 0; t < NT; t++) begin
            for (int s = 0; s < NS; s++) begin
                blk[t*NS+s] = 1'b1; step(); clr();
                chk("R2 blocked", sv(t), BLK);
                chk("R2 other thread", sv(1-t), RUN);
                step();
                chk("R2 sticky", sv(t), BLK);
                ublk[t*NS+s] = 1'b1; step(); clr();
                chk("R2 unblock", sv(t), RUN);
            end
        end

        // R3 / R12: context switch blocks all; stage goes inactive.
        ctx = 1'b1; step(); clr();
        chk("R3 t0", sv(0), BLK); chk("R3 t1", sv(1), BLK);
        chk("R12 all blocked", 32'(act), 0);
        step();
        chk("R7 t0 resumes", sv(0), RUN); chk("R7 t1 resumes", sv(1), RUN);

        // R4..R7: exhaustive priority sweep on thread 0.
        pcm = RPC;
        for (int c = 0; c < 16; c++) begin
            logic [31:0] ct, dt;
            int es;
            ct = 32'h2000 + 32'(c) * 32'h40;
            dt = 32'h8000 + 32'(c) * 32'h10;
            ctgt[0 +: PC_W] = ct; dtgt[0 +: PC_W] = dt;
            cmt[0] = c[0]; rob[0] = c[1]; dec[0] = c[2]; blk[0] = c[3];
            if (c[0]) begin es = SQ; pcm = ct; end
            else if (c[1]) es = SQ;
            else if (c[2]) begin es = SQ; pcm = dt; end
            else if (c[3]) es = BLK;
            else es = RUN;
            step(); clr();
            chk("R4 R5 R6 priority state", sv(0), 32'(es));
            chk("R4 R5 R6 priority pc", pv(0), pcm);
            chk("R4 R6 npc", nv(0), pcm + IB);
            if (c[3]) begin
                step();
                chk("R2 stall bit kept after squash", sv(0), BLK);
                ublk[0] = 1'b1;
            end
            step(); clr();
            chk("R7 recover", sv(0), RUN);
        end

        // R5: reorder-buffer squashing holds Squashing; active stays high.
        rob[1] = 1'b1; step(); step();
        chk("R5 rob hold", sv(1), SQ); chk("R12 squashing active", 32'(act), 1);
        clr(); step(); chk("R7 rob release", sv(1), RUN);

        // R6: decode squash while already Squashing is ignored.
        dec[0] = 1'b1; dtgt[0 +: PC_W] = 32'h4444; step();
        chk("R6 decode redirect", pv(0), 32'h4444);
        dtgt[0 +: PC_W] = 32'h5555; step(); clr();
        chk("R6 ignored pc", pv(0), 32'h4444);
        chk("R7 squash done", sv(0), RUN);

        // R8, R9, R11: miss, stalls ignored, wrong tag, right tag, select.
        mst[0] = 1'b1; step(); clr();
        chk("R8 miss wait", sv(0), MW); chk("R8 tag", tv(0), 1);
        ctx = 1'b1; step(); clr();
        chk("R8 stall ignored in miss", sv(0), MW);
        fv[0] = 1'b1; ftag[0 +: TAG_W] = 3'd0; step(); clr();
        chk("R9 wrong tag", sv(0), MW);
        fv[0] = 1'b1; ftag[0 +: TAG_W] = 3'd1; step(); clr();
        chk("R9 complete", sv(0), MD);
        step(); chk("R11 hold unselected", sv(0), MD);
        sel[0] = 1'b1; step(); clr();
        chk("R11 to running", sv(0), RUN); chk("R11 tag unchanged", tv(0), 1);

        // R9: completion together with a block gives Blocked.
        mst[0] = 1'b1; step(); clr();
        fv[0] = 1'b1; ftag[0 +: TAG_W] = 3'd2; blk[1] = 1'b1; step(); clr();
        chk("R9 stalled completion", sv(0), BLK);
        ublk[1] = 1'b1; step(); clr(); chk("R2 unblock after fill", sv(0), RUN);

        // R10: stale completion after squash is ignored.
        mst[0] = 1'b1; step(); clr();
        cmt[0] = 1'b1; ctgt[0 +: PC_W] = 32'h9000; step(); clr();
        step(); chk("R10 running again", sv(0), RUN);
        mst[0] = 1'b1; step(); clr(); chk("R10 new tag", tv(0), 4);
        fv[0] = 1'b1; ftag[0 +: TAG_W] = 3'd3; step(); clr();
        chk("R10 stale ignored", sv(0), MW);
        fv[0] = 1'b1; ftag[0 +: TAG_W] = 3'd4; step(); clr();
        chk("R10 fresh accepted", sv(0), MD);
        sel[0] = 1'b1; step(); clr();

        // R13 / R12: disabled thread holds; activity needs an enabled thread.
        en[1] = 1'b0;
        cmt[1] = 1'b1; ctgt[PC_W +: PC_W] = 32'h7777; blk[0] = 1'b1; step(); clr();
        chk("R13 disabled state", sv(1), RUN); chk("R13 disabled pc", pv(1), RPC);
        chk("R12 disabled not active", 32'(act), 0);
        en[1] = 1'b1; ublk[0] = 1'b1; step(); clr();
        chk("R12 active again", 32'(act), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule